// File: doc/BRIEF.md
# Protection Key Rights Checker

This block decides whether a data access has to fault because of a memory protection key. It holds two rights registers. One governs user-mode addresses and the other governs supervisor-mode addresses. Each register is loaded through a small write port. A key field in the leaf page-table entry selects one two-bit entry in a rights register. That entry carries an access-disable bit and a write-disable bit.

A page walk feeds the block one paging-structure entry per clock. The block folds the user/supervisor flag of each level into an address type. On the final level it takes the leaf entry, the access type and the control enables. It registers a decision one cycle later. The decision is a key-fault flag and a reason code that separates access-disable faults from write-disable faults.

The register is picked by the type of the address, not by the privilege of the access. Write-disable for supervisor-privilege accesses is further gated by the write-protect control.

Top module: `pkey_rights_checker`

## Requirements
- R1: The key is leaf entry bits 62:59. Key i uses rights bit 2i as access-disable and bit 2i+1 as write-disable, so key 1 uses bits 3:2.
- R2: An address is supervisor-mode if bit 2 (U/S) is 0 in any walked entry, and user-mode only if it is 1 in every level. User-mode addresses use the user register and supervisor-mode addresses use the supervisor register, whatever the access privilege.
- R3: Key checks run only when long-mode paging is on and the enable for the address type is set: the user-key enable for user addresses, the supervisor-key enable for supervisor addresses.
- R4: An instruction fetch never raises a key fault.
- R5: An access flagged as already faulting (not-present or reserved-bit) never raises a key fault.
- R6: When checks run and the selected access-disable bit is 1, any data access faults, read or write, at either privilege.
- R7: A write faults on a set write-disable bit for user-privilege accesses. For supervisor-privilege accesses it faults only when write-protect is 1. Reads never fault on write-disable.
- R8: keyValid pulses high exactly in the cycle after a level strobe marked final, and only then. keyFault and faultReason are zero whenever keyValid is low.
- R9: faultReason is 2'b01 for access-disable, 2'b10 for write-disable and 2'b00 for no fault. Access-disable wins when both apply. keyFault is high exactly when faultReason is nonzero.
- R10: A write with rightsWrSel=0 loads the user register and rightsWrSel=1 loads the supervisor register. It affects walks whose final level comes on a later cycle; a final level in the same cycle as the write uses the old value.
- R11: Reset clears both rights registers, so no access faults until they are written, and drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rightsWrEn | input | 1 | Rights register write strobe |
| rightsWrSel | input | 1 | 0 = user register, 1 = supervisor register |
| rightsWrData | input | 32 | Rights register write value |
| walkValid | input | 1 | A paging-structure entry is presented |
| walkLast | input | 1 | The presented entry is the leaf |
| walkEntry | input | 64 | Paging-structure entry of this level |
| accFetch | input | 1 | Access is an instruction fetch (final level) |
| accWrite | input | 1 | Access is a write (final level) |
| accUser | input | 1 | Access has user privilege (final level) |
| accTermFault | input | 1 | Access already faults as not-present or reserved-bit |
| ctlLongMode | input | 1 | 4/5-level paging active |
| ctlUserKeyEn | input | 1 | User-address key checks enabled |
| ctlSupKeyEn | input | 1 | Supervisor-address key checks enabled |
| ctlWriteProt | input | 1 | Write-protect control |
| keyValid | output | 1 | Decision strobe |
| keyFault | output | 1 | Key fault raised |
| faultReason | output | 2 | 01 access-disable, 10 write-disable, 00 none |

## Verification
Directed walks put a single cleared U/S flag at different levels of a multi-level walk. This tells an all-levels AND apart from a leaf-only test. A supervisor-privilege access to a user address shows whether the register is picked by address type or by privilege. Writes with write-disable set are tried at user and supervisor privilege, with write-protect on and off, and next to reads, which separates the write-disable gating from access-disable. A rights write that lands on the same cycle as a final level shows the exact cycle the new value takes effect. Random walks over levels, keys, rights values and control settings are compared against a bench model.

// File: rtl/pkey_pkg.sv
package pkey_pkg;

  typedef struct packed {
    logic stepLevel;
    logic finishWalk;
  } walk_ctl_t;

  typedef enum logic [1:0] {
    REASON_NONE = 2'b00,
    REASON_AD   = 2'b01,
    REASON_WD   = 2'b10
  } fault_reason_e;

  localparam int unsigned BANK_USER = 0;
  localparam int unsigned BANK_SUP  = 1;
  localparam int unsigned BANK_CNT  = 2;

endpackage

// File: rtl/pkey_control.sv
module pkey_control
  import pkey_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      walkValid,
  input  logic      walkLast,
  output walk_ctl_t walkCtl,
  output logic      keyValid
);

  logic validQ;

  always_comb begin
    walkCtl.stepLevel  = walkValid && !walkLast;
    walkCtl.finishWalk = walkValid && walkLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= walkCtl.finishWalk;
  end

  assign keyValid = validQ;

endmodule

// File: rtl/pkey_datapath.sv
module pkey_datapath
  import pkey_pkg::*;
#(
  parameter int unsigned PTE_W    = 64,
  parameter int unsigned KEY_BITS = 4,
  parameter int unsigned KEY_LSB  = 59,
  parameter int unsigned US_BIT   = 2,
  localparam int unsigned RIGHTS_W = 2 * (2 ** KEY_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  walk_ctl_t           walkCtl,
  input  logic                rightsWrEn,
  input  logic                rightsWrSel,
  input  logic [RIGHTS_W-1:0] rightsWrData,
  input  logic [PTE_W-1:0]    walkEntry,
  input  logic                accFetch,
  input  logic                accWrite,
  input  logic                accUser,
  input  logic                accTermFault,
  input  logic                ctlLongMode,
  input  logic                ctlUserKeyEn,
  input  logic                ctlSupKeyEn,
  input  logic                ctlWriteProt,
  output logic                keyFault,
  output logic [1:0]          faultReason
);

  logic [KEY_BITS-1:0] leafKey;
  logic                usAccQ;
  logic                usAll;
  logic [1:0]          bankEntry [BANK_CNT];
  logic [1:0]          selEntry;
  logic                checkOn;
  logic                wdAllowed;
  logic                adHit;
  logic                wdHit;
  fault_reason_e       reasonNext;
  logic                faultQ;
  fault_reason_e       reasonQ;
  logic                unusedEntryBits;

  assign leafKey         = walkEntry[KEY_LSB +: KEY_BITS];
  assign unusedEntryBits = ^walkEntry;

  // U/S flags fold by AND across the walk; the accumulator re-arms after the leaf.
  always_ff @(posedge clk) begin
    if (!rstN)                   usAccQ <= 1'b1;
    else if (walkCtl.finishWalk) usAccQ <= 1'b1;
    else if (walkCtl.stepLevel)  usAccQ <= usAccQ & walkEntry[US_BIT];
  end

  assign usAll = usAccQ & walkEntry[US_BIT];

  // One rights register per address type, each with its own key lookup.
  for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
    logic [RIGHTS_W-1:0] bankQ;

    always_ff @(posedge clk) begin
      if (!rstN)
        bankQ <= '0;
      else if (rightsWrEn && (rightsWrSel == 1'(b)))
        bankQ <= rightsWrData;
    end

    assign bankEntry[b] = bankQ[{leafKey, 1'b0} +: 2];
  end

  assign selEntry = usAll ? bankEntry[BANK_USER] : bankEntry[BANK_SUP];

  always_comb begin
    checkOn   = ctlLongMode && !accFetch && !accTermFault &&
                (usAll ? ctlUserKeyEn : ctlSupKeyEn);
    wdAllowed = accUser || ctlWriteProt;
    adHit     = checkOn && selEntry[0];
    wdHit     = checkOn && selEntry[1] && accWrite && wdAllowed;
    if (adHit)      reasonNext = REASON_AD;
    else if (wdHit) reasonNext = REASON_WD;
    else            reasonNext = REASON_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultQ  <= 1'b0;
      reasonQ <= REASON_NONE;
    end else if (walkCtl.finishWalk) begin
      faultQ  <= adHit || wdHit;
      reasonQ <= reasonNext;
    end else begin
      faultQ  <= 1'b0;
      reasonQ <= REASON_NONE;
    end
  end

  assign keyFault    = faultQ;
  assign faultReason = reasonQ;

endmodule

// File: rtl/pkey_rights_checker.sv
module pkey_rights_checker
  import pkey_pkg::*;
#(
  parameter int unsigned PTE_W    = 64,
  parameter int unsigned KEY_BITS = 4,
  parameter int unsigned KEY_LSB  = 59,
  parameter int unsigned US_BIT   = 2,
  localparam int unsigned RIGHTS_W = 2 * (2 ** KEY_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rightsWrEn,
  input  logic                rightsWrSel,
  input  logic [RIGHTS_W-1:0] rightsWrData,
  input  logic                walkValid,
  input  logic                walkLast,
  input  logic [PTE_W-1:0]    walkEntry,
  input  logic                accFetch,
  input  logic                accWrite,
  input  logic                accUser,
  input  logic                accTermFault,
  input  logic                ctlLongMode,
  input  logic                ctlUserKeyEn,
  input  logic                ctlSupKeyEn,
  input  logic                ctlWriteProt,
  output logic                keyValid,
  output logic                keyFault,
  output logic [1:0]          faultReason
);

  walk_ctl_t walkCtl;

  pkey_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .walkValid (walkValid),
    .walkLast  (walkLast),
    .walkCtl   (walkCtl),
    .keyValid  (keyValid)
  );

  pkey_datapath #(
    .PTE_W    (PTE_W),
    .KEY_BITS (KEY_BITS),
    .KEY_LSB  (KEY_LSB),
    .US_BIT   (US_BIT)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .walkCtl      (walkCtl),
    .rightsWrEn   (rightsWrEn),
    .rightsWrSel  (rightsWrSel),
    .rightsWrData (rightsWrData),
    .walkEntry    (walkEntry),
    .accFetch     (accFetch),
    .accWrite     (accWrite),
    .accUser      (accUser),
    .accTermFault (accTermFault),
    .ctlLongMode  (ctlLongMode),
    .ctlUserKeyEn (ctlUserKeyEn),
    .ctlSupKeyEn  (ctlSupKeyEn),
    .ctlWriteProt (ctlWriteProt),
    .keyFault     (keyFault),
    .faultReason  (faultReason)
  );

endmodule

// File: rtl/pkey_checker.sv
module pkey_checker (
  input logic       clk,
  input logic       rstN,
  input logic       walkValid,
  input logic       walkLast,
  input logic       accFetch,
  input logic       accTermFault,
  input logic       ctlLongMode,
  input logic       keyValid,
  input logic       keyFault,
  input logic [1:0] faultReason
);

  AST_VALID_AFTER_LEAF: assert property (@(posedge clk) disable iff (!rstN)
    (walkValid && walkLast) |=> keyValid); // R8

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !(walkValid && walkLast) |=> !keyValid); // R8

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !keyValid |-> (!keyFault && faultReason == 2'b00)); // R8

  AST_REASON_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(faultReason)); // R9

  AST_FAULT_HAS_REASON: assert property (@(posedge clk) disable iff (!rstN)
    keyFault == (faultReason != 2'b00)); // R9

  AST_FETCH_NO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (walkValid && walkLast && accFetch) |=> !keyFault); // R4

  AST_TERM_NO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (walkValid && walkLast && accTermFault) |=> !keyFault); // R5

  AST_SHORT_MODE_NO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (walkValid && walkLast && !ctlLongMode) |=> !keyFault); // R3

endmodule

bind pkey_rights_checker pkey_checker i_pkey_checker (
  .clk          (clk),
  .rstN         (rstN),
  .walkValid    (walkValid),
  .walkLast     (walkLast),
  .accFetch     (accFetch),
  .accTermFault (accTermFault),
  .ctlLongMode  (ctlLongMode),
  .keyValid     (keyValid),
  .keyFault     (keyFault),
  .faultReason  (faultReason)
);

// File: tb/test_pkey_rights_checker.sv
module test_pkey_rights_checker;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rightsWrEn;
  logic        rightsWrSel;
  logic [31:0] rightsWrData;
  logic        walkValid;
  logic        walkLast;
  logic [63:0] walkEntry;
  logic        accFetch, accWrite, accUser, accTermFault;
  logic        ctlLongMode, ctlUserKeyEn, ctlSupKeyEn, ctlWriteProt;
  logic        keyValid, keyFault;
  logic [1:0]  faultReason;

  int errors = 0;
  int checks = 0;
  logic [31:0] shUser = '0;
  logic [31:0] shSup  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkey_rights_checker i_pkey_rights_checker (
    .clk(clk), .rstN(rstN),
    .rightsWrEn(rightsWrEn), .rightsWrSel(rightsWrSel), .rightsWrData(rightsWrData),
    .walkValid(walkValid), .walkLast(walkLast), .walkEntry(walkEntry),
    .accFetch(accFetch), .accWrite(accWrite), .accUser(accUser),
    .accTermFault(accTermFault), .ctlLongMode(ctlLongMode),
    .ctlUserKeyEn(ctlUserKeyEn), .ctlSupKeyEn(ctlSupKeyEn),
    .ctlWriteProt(ctlWriteProt),
    .keyValid(keyValid), .keyFault(keyFault), .faultReason(faultReason)
  );

  task automatic checkEq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Returns {fault, reason}
  function automatic logic [2:0] model(int levels, logic [7:0] usMask, logic [3:0] key,
      logic fetch, logic wr, logic usr, logic term, logic lm, logic uke, logic ske,
      logic wp, logic [31:0] ru, logic [31:0] rs);
    logic userAddr = 1'b1;
    logic [31:0] bank;
    logic en, ad, wd, adF, wdF;
    for (int l = 0; l < levels; l++) userAddr &= usMask[l];
    bank = userAddr ? ru : rs;
    ad   = bank[2*key];
    wd   = bank[2*key+1];
    en   = lm && (userAddr ? uke : ske) && !fetch && !term;
    adF  = en && ad;
    wdF  = en && wd && wr && (usr || wp);
    return {adF || wdF, adF ? 2'b01 : (wdF ? 2'b10 : 2'b00)};
  endfunction

  task automatic writeRights(logic sel, logic [31:0] data);
    @(negedge clk);
    rightsWrEn = 1'b1; rightsWrSel = sel; rightsWrData = data;
    @(negedge clk);
    rightsWrEn = 1'b0;
    if (sel) shSup = data; else shUser = data;
  endtask

  task automatic runAccess(string req, int levels, logic [7:0] usMask, logic [3:0] key,
      logic fetch, logic wr, logic usr, logic term, logic lm, logic uke, logic ske,
      logic wp, logic doWr = 1'b0, logic wrSel = 1'b0, logic [31:0] wrData = '0);
    logic [2:0]  exp;
    logic [63:0] ent;
    exp = model(levels, usMask, key, fetch, wr, usr, term, lm, uke, ske, wp, shUser, shSup);
    for (int l = 0; l < levels; l++) begin
      @(negedge clk);
      ent = {$urandom, $urandom};
      if (l == levels - 1) ent[62:59] = key;
      ent[2] = usMask[l];
      walkValid = 1'b1;
      walkLast  = (l == levels - 1);
      walkEntry = ent;
      accFetch = fetch; accWrite = wr; accUser = usr; accTermFault = term;
      ctlLongMode = lm; ctlUserKeyEn = uke; ctlSupKeyEn = ske; ctlWriteProt = wp;
      if (l == levels - 1 && doWr) begin
        rightsWrEn = 1'b1; rightsWrSel = wrSel; rightsWrData = wrData;
      end
    end
    @(negedge clk);
    checkEq({req, " R8 valid"}, 32'(keyValid), 32'd1);
    checkEq({req, " fault"}, 32'(keyFault), 32'(exp[2]));
    checkEq({req, " R9 reason"}, 32'(faultReason), 32'(exp[1:0]));
    walkValid = 1'b0; walkLast = 1'b0; rightsWrEn = 1'b0;
    if (doWr) begin
      if (wrSel) shSup = wrData; else shUser = wrData;
    end
    @(negedge clk);
    checkEq("R8 idle valid", 32'(keyValid), 32'd0);
    checkEq("R8 idle fault", 32'(keyFault), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20211));
    rstN = 1'b0; rightsWrEn = 1'b0; rightsWrSel = 1'b0; rightsWrData = '0;
    walkValid = 1'b0; walkLast = 1'b0; walkEntry = '0;
    accFetch = 0; accWrite = 0; accUser = 0; accTermFault = 0;
    ctlLongMode = 0; ctlUserKeyEn = 0; ctlSupKeyEn = 0; ctlWriteProt = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R11 reset valid", 32'(keyValid), 32'd0);
    checkEq("R11 reset fault", 32'(keyFault), 32'd0);
    checkEq("R11 reset reason", 32'(faultReason), 32'd0);

    // R11: cleared registers restrict nothing
    runAccess("R11 user addr", 4, 8'hFF, 4'd3, 0, 1, 1, 0, 1, 1, 1, 1);
    runAccess("R11 sup addr",  4, 8'h00, 4'd9, 0, 1, 0, 0, 1, 1, 1, 1);

    // R1 / R6: key 1 access-disable sits in bit 2
    writeRights(1'b0, 32'h0000_0024);
    runAccess("R1 R6 key1 read",   4, 8'hFF, 4'd1, 0, 0, 1, 0, 1, 1, 1, 0);
    runAccess("R1 key0 clear",     4, 8'hFF, 4'd0, 0, 0, 1, 0, 1, 1, 1, 0);
    runAccess("R6 key1 sup write", 4, 8'hFF, 4'd1, 0, 1, 0, 0, 1, 1, 1, 0);

    // R2: supervisor access to user address uses user register
    runAccess("R2 sup priv user addr", 4, 8'hFF, 4'd1, 0, 0, 0, 0, 1, 1, 1, 1);
    runAccess("R2 mid level U/S=0",    4, 8'hFD, 4'd1, 0, 0, 1, 0, 1, 1, 1, 1);
    runAccess("R2 first level U/S=0",  5, 8'hFE, 4'd1, 0, 0, 1, 0, 1, 1, 1, 1);

    // R3: enables
    runAccess("R3 no long mode",  4, 8'hFF, 4'd1, 0, 0, 1, 0, 0, 1, 1, 1);
    runAccess("R3 user key off",  4, 8'hFF, 4'd1, 0, 0, 1, 0, 1, 0, 1, 1);

    // R4, R5
    runAccess("R4 fetch", 4, 8'hFF, 4'd1, 1, 0, 1, 0, 1, 1, 1, 1);
    runAccess("R5 term",  4, 8'hFF, 4'd1, 0, 0, 1, 1, 1, 1, 1, 1);

    // R7: key 2 write-disable (bit 5) in both registers
    writeRights(1'b1, 32'h0000_0020);
    runAccess("R7 user write wp0",     4, 8'hFF, 4'd2, 0, 1, 1, 0, 1, 1, 1, 0);
    runAccess("R7 sup write wp0",      4, 8'hF7, 4'd2, 0, 1, 0, 0, 1, 1, 1, 0);
    runAccess("R7 sup write wp1",      4, 8'hF7, 4'd2, 0, 1, 0, 0, 1, 1, 1, 1);
    runAccess("R7 read with wd",       4, 8'hF7, 4'd2, 0, 0, 0, 0, 1, 1, 1, 1);
    runAccess("R3 sup key off",        4, 8'hF7, 4'd2, 0, 1, 0, 0, 1, 1, 0, 1);

    // R9: access-disable wins over write-disable (key 7, bits 15:14)
    writeRights(1'b1, 32'h0000_C000);
    runAccess("R9 both bits", 4, 8'h00, 4'd7, 0, 1, 0, 0, 1, 1, 1, 1);

    // R10: write in the same cycle as the final level is not yet seen
    runAccess("R10 same cycle", 4, 8'hFF, 4'd4, 0, 0, 1, 0, 1, 1, 1, 1, 1'b1, 1'b0, 32'h0000_0100);
    runAccess("R10 next access", 4, 8'hFF, 4'd4, 0, 0, 1, 0, 1, 1, 1, 1);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int lv;
      logic [7:0] mask;
      lv   = 1 + int'($urandom_range(0, 4));
      mask = ($urandom_range(0, 1) == 0) ? 8'hFF : 8'($urandom);
      if ($urandom_range(0, 5) == 0)
        writeRights(1'($urandom), $urandom);
      runAccess("R2 R6 R7 random", lv, mask, 4'($urandom),
                ($urandom_range(0, 7) == 0), 1'($urandom), 1'($urandom),
                ($urandom_range(0, 7) == 0), ($urandom_range(0, 5) != 0),
                ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0),
                1'($urandom), ($urandom_range(0, 9) == 0), 1'($urandom), $urandom);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule